// File: doc/BRIEF.md
# Diagnostic Tap Selector with Clock Bypass

This block drives one diagnostic output pin from one of eight internal nodes, picked by a 3-bit tap code. The nodes are two constant levels, the serial configuration data bit, the reference clock divided by sixteen, the pulse output of a modulo-M counter, the main output clock, and that clock divided by four. All inputs are sampled in a single fast system clock domain. Each slow clock is seen as a level, and its rising edges are found by comparing the current sample with the previous one.

One code reroutes the main clock path instead of only observing it. In bypass, the serial configuration clock steps the modulo-M counter and a power-of-two post-divider. The post-divider output replaces the main output clock, and the counter pulse appears on the diagnostic pin. Outside bypass, the modulo-M counter is stepped by a stand-in feedback clock, which models the loop feedback path, and the main clock input passes straight to the main output.

A new tap code takes effect at once when the current tap is a constant or the data bit. When the current tap is a clock, the new code waits until that clock is low, so the diagnostic pin never shows a runt pulse.

Top module: `diag_tap_mux`

## Requirements
- R1: Tap code 3'b001 drives the diagnostic output to a constant 1, and tap code 3'b101 drives it to a constant 0, whatever the other inputs do.
- R2: Tap code 3'b000 places the sampled serial data bit on the diagnostic output.
- R3: Tap code 3'b010 gives the reference clock divided by 16. After reset the output goes high on the 8th rising reference edge and low again on the 16th.
- R4: Tap code 3'b011 shows the modulo-M counter. With M >= 1, the output goes high on every M-th rising edge of its stepping clock and stays high until the next rising edge.
- R5: When M is 0, the counter output is held low and the counter is held cleared.
- R6: Tap code 3'b100 shows the main clock input level. Tap code 3'b111 gives the main clock divided by 4: after reset it is high after the 2nd and 3rd rising edges and low after the 4th.
- R7: Tap code 3'b110 is bypass. The main output shows the serial clock divided by 2^N, where the N code is 0 to 3 and code 0 follows the serial clock level. The counter then steps on serial clock edges, and its pulse drives the diagnostic output. In bypass, the main clock input and the feedback clock have no effect on either output.
- R8: With any tap code other than 3'b110, the main output follows the main clock input.
- R9: When the active tap is a clock (codes 010, 011, 100, 110, 111), a new tap code takes effect only in a cycle where that clock is low. When the active tap is 000, 001 or 101, a new code takes effect at once.
- R10: Reset makes tap 000 active, clears every divider and counter, and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| t_code | input | 3 | Requested tap code |
| ref_clk | input | 1 | Reference clock |
| ser_clk | input | 1 | Serial configuration clock |
| ser_bit | input | 1 | Serial shift-register output bit |
| fb_clk | input | 1 | Stand-in feedback clock that steps the M counter outside bypass |
| main_clk_in | input | 1 | Main synthesized clock |
| m_val | input | MW (9) | Modulo-M counter length |
| n_code | input | NW (2) | Post-divider code, ratio 2^n_code |
| main_clk_out | output | 1 | Main output clock (passthrough, or divided serial clock in bypass) |
| diag_out | output | 1 | Diagnostic output |

## Verification
The bench builds the block with its default widths: a 9-bit M and a 2-bit N code. Small M values (0, 3 and 5) bring a counter wrap and the M-equals-zero hold within a few feedback or serial pulses. N codes 0 and 1 cover both the level-following path and a real division in bypass. The four-stage reference divider reaches its 8th-edge and 16th-edge transitions in a short run, and a held-high main clock shows the deferred tap switch.

// File: rtl/diag_tap_pkg.sv
package diag_tap_pkg;
  typedef enum logic [2:0] {
    TAP_SHIFT  = 3'b000,
    TAP_ONE    = 3'b001,
    TAP_REF16  = 3'b010,
    TAP_MCNT   = 3'b011,
    TAP_MAIN   = 3'b100,
    TAP_ZERO   = 3'b101,
    TAP_BYPASS = 3'b110,
    TAP_MAIN4  = 3'b111
  } tap_e;

  // Taps that never need a low-phase wait before a switch away
  function automatic logic tap_is_static(input logic [2:0] t);
    return (t == TAP_SHIFT) || (t == TAP_ONE) || (t == TAP_ZERO);
  endfunction
endpackage

// File: rtl/diag_tap_sampler.sv
// Samples W slow clock levels and flags their rising edges.
module diag_tap_sampler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
    end
  end

  assign lvl  = s1_q;
  assign rise = s1_q & ~s2_q;
endmodule

// File: rtl/diag_tap_pow2_div.sv
// Ripple-free power-of-two divider: counts qualified rising edges, picks a tap.
module diag_tap_pow2_div #(
  parameter int STAGES = 4,
  localparam int SW = $clog2(STAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          rise,
  input  logic          lvl,
  input  logic [SW-1:0] ratio_log2,
  output logic          div_out
);
  logic [STAGES-1:0] cnt_q, cnt_d;
  logic [STAGES:0]   taps;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en && rise) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign taps[0] = lvl;
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign taps[k] = cnt_q[k-1];
  end

  assign div_out = taps[ratio_log2];
endmodule

// File: rtl/diag_tap_mcount.sv
// Modulo-M counter: pulse held high from every M-th tick until the next tick.
module diag_tap_mcount #(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [MW-1:0] m_val,
  output logic          m_out
);
  logic [MW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic [MW-1:0] last_val;

  assign last_val = m_val - 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (m_val == '0) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == last_val) begin
        cnt_d = '0;
        out_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign m_out = out_q;
endmodule

// File: rtl/diag_tap_mux.sv
module diag_tap_mux
  import diag_tap_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int REF_LOG2 = 4,
  parameter int MAIN_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    t_code,
  input  logic          ref_clk,
  input  logic          ser_clk,
  input  logic          ser_bit,
  input  logic          fb_clk,
  input  logic          main_clk_in,
  input  logic [MW-1:0] m_val,
  input  logic [NW-1:0] n_code,
  output logic          main_clk_out,
  output logic          diag_out
);
  localparam int NSTG   = (1 << NW) - 1;
  localparam int REF_SW = $clog2(REF_LOG2 + 1);
  localparam int MN_SW  = $clog2(MAIN_LOG2 + 1);
  localparam int I_REF = 0, I_SER = 1, I_FB = 2, I_MAIN = 3;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Clock level sampling
  logic [3:0] lvl, rise;
  diag_tap_sampler #(.W(4)) u_smp (
    .clk (clk), .rst_n (rst_q),
    .raw ({main_clk_in, fb_clk, ser_clk, ref_clk}),
    .lvl (lvl), .rise (rise)
  );
  logic unused_fb_lvl;
  assign unused_fb_lvl = lvl[I_FB];

  logic ser_bit_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ser_bit_q <= 1'b0;
    else        ser_bit_q <= ser_bit;
  end

  // Active tap selection
  logic [2:0] sel_q, sel_d;
  logic       bypass_q;
  assign bypass_q = (sel_q == TAP_BYPASS);

  // Dividers and counter
  logic ref16, main4, ndiv, m_out, m_tick;

  diag_tap_pow2_div #(.STAGES(REF_LOG2)) u_ref_div (
    .clk (clk), .rst_n (rst_q), .cnt_en (1'b1),
    .rise (rise[I_REF]), .lvl (lvl[I_REF]),
    .ratio_log2 (REF_SW'(REF_LOG2)), .div_out (ref16)
  );

  diag_tap_pow2_div #(.STAGES(MAIN_LOG2)) u_main_div (
    .clk (clk), .rst_n (rst_q), .cnt_en (1'b1),
    .rise (rise[I_MAIN]), .lvl (lvl[I_MAIN]),
    .ratio_log2 (MN_SW'(MAIN_LOG2)), .div_out (main4)
  );

  diag_tap_pow2_div #(.STAGES(NSTG)) u_n_div (
    .clk (clk), .rst_n (rst_q), .cnt_en (bypass_q),
    .rise (rise[I_SER]), .lvl (lvl[I_SER]),
    .ratio_log2 (n_code), .div_out (ndiv)
  );

  assign m_tick = bypass_q ? rise[I_SER] : rise[I_FB];

  diag_tap_mcount #(.MW(MW)) u_mcnt (
    .clk (clk), .rst_n (rst_q), .tick (m_tick),
    .m_val (m_val), .m_out (m_out)
  );

  // Source vector indexed by tap code
  logic [7:0] src;
  always_comb begin
    src             = '0;
    src[TAP_SHIFT]  = ser_bit_q;
    src[TAP_ONE]    = 1'b1;
    src[TAP_REF16]  = ref16;
    src[TAP_MCNT]   = m_out;
    src[TAP_MAIN]   = lvl[I_MAIN];
    src[TAP_ZERO]   = 1'b0;
    src[TAP_BYPASS] = m_out;
    src[TAP_MAIN4]  = main4;
  end

  logic cur_src, switch_ok;
  assign cur_src   = src[sel_q];
  assign switch_ok = tap_is_static(sel_q) || !cur_src;

  // Next state
  logic diag_d, main_d;
  always_comb begin
    sel_d  = switch_ok ? t_code : sel_q;
    diag_d = src[sel_d];
    main_d = (sel_d == TAP_BYPASS) ? ndiv : lvl[I_MAIN];
  end

  // Registers
  logic diag_q, main_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_q  <= TAP_SHIFT;
      diag_q <= 1'b0;
      main_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      diag_q <= diag_d;
      main_q <= main_d;
    end
  end

  assign diag_out     = diag_q;
  assign main_clk_out = main_q;
endmodule

// File: rtl/diag_tap_mux_chk.sv
module diag_tap_mux_chk #(
  parameter int MW = 9
) (
  input logic          clk,
  input logic          rst_q,
  input logic [2:0]    t_code,
  input logic [2:0]    sel_q,
  input logic          cur_src,
  input logic          diag_out,
  input logic          main_clk_out,
  input logic          main_lvl,
  input logic [MW-1:0] m_val,
  input logic          m_out,
  input logic          m_tick
);
  assert_const_one_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_q == 3'b001 && t_code == 3'b001) |=> diag_out);

  assert_const_zero_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_q == 3'b101 && t_code == 3'b101) |=> !diag_out);

  assert_mpulse_one_tick_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (m_out && m_tick && m_val > 1) |=> !m_out);

  assert_mzero_low_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (m_val == '0) |=> !m_out);

  assert_pass_main_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_q != 3'b110 && t_code != 3'b110) |=> main_clk_out == $past(main_lvl));

  assert_hold_while_high_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_q != 3'b000 && sel_q != 3'b001 && sel_q != 3'b101 && cur_src)
      |=> sel_q == $past(sel_q));
endmodule

bind diag_tap_mux diag_tap_mux_chk #(.MW(MW)) u_chk (
  .clk (clk), .rst_q (rst_q), .t_code (t_code), .sel_q (sel_q),
  .cur_src (cur_src), .diag_out (diag_out), .main_clk_out (main_clk_out),
  .main_lvl (lvl[3]), .m_val (m_val), .m_out (m_out), .m_tick (m_tick)
);

// File: tb/sim_diag_tap_mux.sv
module sim_diag_tap_mux;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] t_code;
  logic       ref_clk, ser_clk, ser_bit, fb_clk, main_clk_in;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic       main_clk_out, diag_out;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  diag_tap_mux u0 (
    .clk (clk), .rst_n (rst_n), .t_code (t_code), .ref_clk (ref_clk),
    .ser_clk (ser_clk), .ser_bit (ser_bit), .fb_clk (fb_clk),
    .main_clk_in (main_clk_in), .m_val (m_val), .n_code (n_code),
    .main_clk_out (main_clk_out), .diag_out (diag_out)
  );

  // {tap code, data bit, expected diag}
  localparam logic [4:0] VEC [0:5] = '{
    5'b001_0_1, 5'b101_1_0, 5'b000_1_1,
    5'b000_0_0, 5'b001_1_1, 5'b101_0_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sig = 1'b1;
      repeat (6) @(negedge clk);
      sig = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    t_code = 3'b000; ser_bit = 1'b0; ref_clk = 1'b0; ser_clk = 1'b0;
    fb_clk = 1'b0; main_clk_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; m_val = 9'd5; n_code = 2'd1;
    do_reset();
    // R10: reset state
    chk("R10 diag after reset", diag_out, 1'b0);
    chk("R10 main after reset", main_clk_out, 1'b0);

    // R1 / R2: static and data taps, switched at once (R9)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      t_code  = VEC[i][4:2];
      ser_bit = VEC[i][1];
      settle();
      chk("R1/R2 static vector", diag_out, VEC[i][0]);
    end

    // R3: reference divided by 16
    do_reset();
    t_code = 3'b010; settle();
    pulse(ref_clk, 7);
    chk("R3 ref16 after 7 edges", diag_out, 1'b0);
    pulse(ref_clk, 1);
    chk("R3 ref16 after 8 edges", diag_out, 1'b1);
    pulse(ref_clk, 8);
    chk("R3 ref16 after 16 edges", diag_out, 1'b0);

    // R4: M counter pulse from feedback clock, M=5
    do_reset();
    m_val = 9'd5; t_code = 3'b011; settle();
    pulse(fb_clk, 4);
    chk("R4 mcount after 4 ticks", diag_out, 1'b0);
    pulse(fb_clk, 1);
    chk("R4 mcount after 5 ticks", diag_out, 1'b1);
    pulse(fb_clk, 1);
    chk("R4 mcount after 6 ticks", diag_out, 1'b0);

    // R5: M of zero holds low
    do_reset();
    m_val = 9'd0; t_code = 3'b011; settle();
    for (int i = 0; i < 4; i++) begin
      pulse(fb_clk, 1);
      chk("R5 M=0 stays low", diag_out, 1'b0);
    end

    // R6 main clock tap, R8 passthrough, R9 deferred switch
    do_reset();
    t_code = 3'b100; settle();
    main_clk_in = 1'b1; settle();
    chk("R6 main tap high", diag_out, 1'b1);
    chk("R8 main passthrough high", main_clk_out, 1'b1);
    t_code = 3'b101; settle();
    chk("R9 switch held while source high", diag_out, 1'b1);
    main_clk_in = 1'b0; settle();
    chk("R8 main passthrough low", main_clk_out, 1'b0);
    main_clk_in = 1'b1; settle();
    chk("R9 switch done on low phase", diag_out, 1'b0);
    main_clk_in = 1'b0;

    // R6: main divided by 4
    do_reset();
    t_code = 3'b111; settle();
    pulse(main_clk_in, 1);
    chk("R6 main4 after 1 edge", diag_out, 1'b0);
    pulse(main_clk_in, 1);
    chk("R6 main4 after 2 edges", diag_out, 1'b1);
    pulse(main_clk_in, 1);
    chk("R6 main4 after 3 edges", diag_out, 1'b1);
    pulse(main_clk_in, 1);
    chk("R6 main4 after 4 edges", diag_out, 1'b0);

    // R7: bypass, N code 1 (divide by 2), M=3
    do_reset();
    m_val = 9'd3; n_code = 2'd1; t_code = 3'b110; settle();
    pulse(ser_clk, 1);
    chk("R7 bypass main after 1", main_clk_out, 1'b1);
    chk("R7 bypass diag after 1", diag_out, 1'b0);
    pulse(ser_clk, 1);
    chk("R7 bypass main after 2", main_clk_out, 1'b0);
    pulse(ser_clk, 1);
    chk("R7 bypass main after 3", main_clk_out, 1'b1);
    chk("R7 bypass diag after 3", diag_out, 1'b1);
    pulse(fb_clk, 2);
    chk("R7 feedback ignored in bypass", diag_out, 1'b1);
    main_clk_in = 1'b1; settle();
    chk("R7 main input ignored in bypass", main_clk_out, 1'b1);
    main_clk_in = 1'b0;
    pulse(ser_clk, 1);
    chk("R7 bypass diag after 4", diag_out, 1'b0);
    chk("R7 bypass main after 4", main_clk_out, 1'b0);
    // N code 0 follows serial clock level
    n_code = 2'd0;
    ser_clk = 1'b1; settle();
    chk("R7 N=0 follows high", main_clk_out, 1'b1);
    ser_clk = 1'b0; settle();
    chk("R7 N=0 follows low", main_clk_out, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule